// File: doc/BRIEF.md
# Multi-Channel Serial Audio Transmitter

This block turns a stream of PCM samples into a three-wire serial audio signal: a bit clock, a word-select line and a serial data line. It divides the system clock down to the bit clock itself. A frame is two system words, one for each level of word select. Each system word carries one to four data words, sent back to back. The positions left over in the system word are filled with a constant padding bit, placed either before or after the data.

The word lengths, the number of data words per system word, the polarity of the clock and of word select, a one-bit data delay and the padding position are all set at run time. The configuration is captured while the transmitter is idle. A configuration whose data words do not fit in a system word is flagged and never starts. Samples come in over a valid/ready handshake, one per data word. If no sample is offered when a data word falls due, zeros go out and a sticky underflow flag is raised.

Top module: `sat_tx`

## Requirements
- R1: Each data word is sent most significant bit first, using the low `dwl` bits of `s_data`; bits above that length are ignored. System word length codes 0..7 select 8, 16, 24, 32, 48, 64, 128 and 256 bits. Data word length codes 0..5 select 8, 16, 18, 20, 22 and 24 bits.
- R2: With `cfg_pad_first`=0, the data bits occupy the first `n*dwl` positions of each system word and the padding follows. Here n is `cfg_chan`+1, the number of data words per system word.
- R3: With `cfg_pad_first`=1, the padding comes first and the data occupies the last `n*dwl` positions, so the last data LSB is the final bit before word select changes.
- R4: With `cfg_delay`=1, every bit lands one bit-clock period later than with `cfg_delay`=0, while word select keeps its timing. The first bit of a system word therefore follows the word-select change by one period. The bit in the very first period after start is 0.
- R5: With `cfg_sck_inv`=0 and `cfg_ws_inv`=0, data and word select change on the falling bit-clock edge and word select is low during the first system word of each frame. Each inversion control inverts its own line. The bit clock period is 2*(`cfg_div`+1) system clocks.
- R6: `cfg_err` is 1 when the data length code is 6 or 7, or when n*dwl exceeds the system word length. An exact fit is valid. While `cfg_err` is 1, raising `en` produces no bit-clock edge and no `s_ready`.
- R7: Every padding bit equals `cfg_pad_val`.
- R8: One sample is accepted (`s_valid` and `s_ready` both 1 in a cycle) per data word, at the launch of that word's MSB. Samples fill channels in ascending order, first system word before second.
- R9: If `s_valid` is 0 when a data word falls due, that word is sent as zeros and `underflow` is set. The flag stays set until a cycle with `ufl_clr`=1, and a new underflow wins over a clear in the same cycle.
- R10: When `en` is 0 at the end of a frame, the transmitter stops after whole frames. When idle, the bit clock rests at its high level (inverted by `cfg_sck_inv`), `sd` is 0 and word select rests at the level of the second system word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run request, sampled at frame boundaries |
| cfg_swl | input | 3 | System word length code |
| cfg_dwl | input | 3 | Data word length code |
| cfg_chan | input | 2 | Data words per system word minus one |
| cfg_div | input | DIV_W | Bit clock half-period minus one, in system clocks |
| cfg_sck_inv | input | 1 | Bit clock inversion |
| cfg_ws_inv | input | 1 | Word select inversion |
| cfg_delay | input | 1 | One-bit data delay after word select |
| cfg_pad_first | input | 1 | Padding before data when 1 |
| cfg_pad_val | input | 1 | Value of padding bits |
| s_valid | input | 1 | Sample offered |
| s_data | input | MAXW | Sample, right-aligned |
| s_ready | output | 1 | Sample taken this cycle |
| ufl_clr | input | 1 | Clears the underflow flag |
| underflow | output | 1 | Sticky underflow flag |
| cfg_err | output | 1 | Present configuration is invalid |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select |
| sd | output | 1 | Serial data |

## Verification
The bench compares every received bit and word-select level against a stream it builds from its own length tables. A misplaced data region (padding on the wrong side) or a misaligned word boundary would show up as a data bit appearing in a padding slot. The bench also checks an exact-fit configuration with no padding at all. A delay that shifted word select along with the data, or that leaked a stale bit into the first slot, would fail the comparison.

Stopping is checked by counting bit-clock edges and handshakes. A design that halts mid-frame, or that takes a sample for padding, would give the wrong counts. An over-long configuration, and a sample-starved run expecting zeros and a sticky flag that a single clear pulse resets, cover the rejection and underflow paths.

// File: rtl/sat_pkg.sv
package sat_pkg;

   localparam int SWL_W = 9;
   localparam int DWL_W = 5;
   localparam int NW_W  = 3;

   typedef struct packed {
      logic [SWL_W-1:0] swl;
      logic [DWL_W-1:0] dwl;
      logic [NW_W-1:0]  nw;
      logic             sckp;
      logic             wsp;
      logic             del;
      logic             padfirst;
      logic             padval;
   } sat_cfg_t;

   function automatic logic [SWL_W-1:0] swl_decode(input logic [2:0] code);
      case (code)
         3'd0:    return 9'd8;
         3'd1:    return 9'd16;
         3'd2:    return 9'd24;
         3'd3:    return 9'd32;
         3'd4:    return 9'd48;
         3'd5:    return 9'd64;
         3'd6:    return 9'd128;
         default: return 9'd256;
      endcase
   endfunction

   // zero marks an unsupported code
   function automatic logic [DWL_W-1:0] dwl_decode(input logic [2:0] code);
      case (code)
         3'd0:    return 5'd8;
         3'd1:    return 5'd16;
         3'd2:    return 5'd18;
         3'd3:    return 5'd20;
         3'd4:    return 5'd22;
         3'd5:    return 5'd24;
         default: return 5'd0;
      endcase
   endfunction

endpackage

// File: rtl/sat_cfg_check.sv
module sat_cfg_check
   import sat_pkg::*;
(
   input  logic [2:0] swl_code,
   input  logic [2:0] dwl_code,
   input  logic [1:0] chan_code,
   input  logic       sckp,
   input  logic       wsp,
   input  logic       del,
   input  logic       padfirst,
   input  logic       padval,
   output sat_cfg_t   cfg,
   output logic       ok
);

   logic [7:0] dbits;

   always_comb begin
      cfg.swl      = swl_decode(swl_code);
      cfg.dwl      = dwl_decode(dwl_code);
      cfg.nw       = {1'b0, chan_code} + 3'd1;
      cfg.sckp     = sckp;
      cfg.wsp      = wsp;
      cfg.del      = del;
      cfg.padfirst = padfirst;
      cfg.padval   = padval;
      dbits        = 8'(cfg.nw) * 8'(cfg.dwl);
      ok           = (cfg.dwl != '0) && ({1'b0, dbits} <= cfg.swl);
   end

endmodule

// File: rtl/sat_bclk_gen.sv
module sat_bclk_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             cont,
   input  logic [DIV_W-1:0] div,
   output logic             tick,
   output logic             sck_int
);

   logic [DIV_W-1:0] cnt;
   logic             ph;

   // tick: the start of a bit period (falling internal clock)
   assign tick    = go && (cnt == '0) && ph;
   assign sck_int = ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         ph  <= 1'b1;
      end else if (!go) begin
         cnt <= '0;
         ph  <= 1'b1;
      end else if (cnt == '0) begin
         if (ph && !cont) begin
            cnt <= '0;
         end else begin
            cnt <= div;
            ph  <= ~ph;
         end
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

   a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (go && cnt != '0) |=> $stable(ph));

   a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= div);

endmodule

// File: rtl/sat_frame_seq.sv
module sat_frame_seq
   import sat_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             cfg_ok,
   input  logic [SWL_W-1:0] swl,
   input  logic [DWL_W-1:0] dwl,
   input  logic [NW_W-1:0]  nw,
   input  logic             padfirst,
   input  logic             tick,
   output logic             busy,
   output logic             go,
   output logic             cont,
   output logic             launch,
   output logic             stop,
   output logic             in_data,
   output logic             word_start,
   output logic             ws_int
);

   localparam int EXT_W = SWL_W + 1;

   logic             half;
   logic [SWL_W-1:0] pos;
   logic [DWL_W-1:0] wb;
   logic             nh;
   logic [SWL_W-1:0] np;
   logic [DWL_W-1:0] nwb;
   logic [7:0]       dbits;
   logic [EXT_W-1:0] ds;
   logic [EXT_W-1:0] de;
   logic             last;

   always_comb begin
      dbits  = 8'(nw) * 8'(dwl);
      ds     = padfirst ? (EXT_W'(swl) - EXT_W'(dbits)) : '0;
      de     = ds + EXT_W'(dbits);
      last   = busy && half && (pos == swl - 9'd1);
      cont   = busy ? !(last && !en) : (en && cfg_ok);
      go     = busy || (en && cfg_ok);
      launch = tick && cont;
      stop   = tick && !cont;

      if (!busy) begin
         nh = 1'b0;
         np = '0;
      end else if (pos == swl - 9'd1) begin
         nh = ~half;
         np = '0;
      end else begin
         nh = half;
         np = pos + 9'd1;
      end

      in_data = ({1'b0, np} >= ds) && ({1'b0, np} < de);
      if ({1'b0, np} == ds)
         nwb = '0;
      else if (wb == dwl - 5'd1)
         nwb = '0;
      else
         nwb = wb + 5'd1;
      word_start = in_data && (nwb == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         half   <= 1'b0;
         pos    <= '0;
         wb     <= '0;
         ws_int <= 1'b1;
      end else if (tick) begin
         if (cont) begin
            busy   <= 1'b1;
            half   <= nh;
            pos    <= np;
            wb     <= nwb;
            ws_int <= nh;
         end else begin
            busy   <= 1'b0;
            half   <= 1'b0;
            pos    <= '0;
            wb     <= '0;
            ws_int <= 1'b1;
         end
      end
   end

   a_r6_no_start_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cfg_ok) |=> !busy);

   a_r1_pos_in_word: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (pos < swl));

   a_r5_ws_only_at_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> $stable(ws_int));

   a_r10_stop_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(last));

endmodule

// File: rtl/sat_shifter.sv
module sat_shifter
   import sat_pkg::*;
#(
   parameter int MAXW = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             stop,
   input  logic             in_data,
   input  logic             word_start,
   input  logic [DWL_W-1:0] dwl,
   input  logic             padval,
   input  logic             s_valid,
   input  logic [MAXW-1:0]  s_data,
   input  logic             ufl_clr,
   output logic             s_ready,
   output logic             sd_cur,
   output logic             sd_prev,
   output logic             underflow
);

   localparam int AW = $clog2(MAXW + 1);

   logic [MAXW-1:0] sh;
   logic [MAXW-1:0] loaded;
   logic [MAXW-1:0] aligned;
   logic [AW-1:0]   sh_amt;
   logic            bit_new;

   always_comb begin
      loaded  = s_valid ? s_data : '0;
      sh_amt  = AW'(MAXW) - AW'(dwl);
      aligned = loaded << sh_amt;
      if (!in_data)
         bit_new = padval;
      else if (word_start)
         bit_new = aligned[MAXW-1];
      else
         bit_new = sh[MAXW-1];
   end

   assign s_ready = launch && word_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         sd_cur  <= 1'b0;
         sd_prev <= 1'b0;
      end else if (launch) begin
         sd_prev <= sd_cur;
         sd_cur  <= bit_new;
         if (in_data)
            sh <= (word_start ? aligned : sh) << 1;
      end else if (stop) begin
         sd_cur  <= 1'b0;
         sd_prev <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         underflow <= 1'b0;
      else if (launch && word_start && !s_valid)
         underflow <= 1'b1;
      else if (ufl_clr)
         underflow <= 1'b0;
   end

   a_r9_ufl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow && !ufl_clr) |=> underflow);

   a_r9_ufl_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underflow) |-> $past(launch && !s_valid));

endmodule

// File: rtl/sat_tx.sv
module sat_tx
   import sat_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int MAXW  = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [2:0]       cfg_swl,
   input  logic [2:0]       cfg_dwl,
   input  logic [1:0]       cfg_chan,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             cfg_sck_inv,
   input  logic             cfg_ws_inv,
   input  logic             cfg_delay,
   input  logic             cfg_pad_first,
   input  logic             cfg_pad_val,
   input  logic             s_valid,
   input  logic [MAXW-1:0]  s_data,
   output logic             s_ready,
   input  logic             ufl_clr,
   output logic             underflow,
   output logic             cfg_err,
   output logic             sck,
   output logic             ws,
   output logic             sd
);

   generate
      if (MAXW < 24) begin : g_bad_maxw
         $error("sat_tx: MAXW must hold the longest data word (24)");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("sat_tx: DIV_W must be at least 1");
      end
   endgenerate

   sat_cfg_t         cfg_live;
   sat_cfg_t         cfg_q;
   logic             ok_live;
   logic             ok_q;
   logic [DIV_W-1:0] div_q;

   logic busy, go, cont, tick, launch, stop;
   logic in_data, word_start, ws_int, sck_int;
   logic sd_cur, sd_prev;

   sat_cfg_check u_cfg (
      .swl_code  (cfg_swl),
      .dwl_code  (cfg_dwl),
      .chan_code (cfg_chan),
      .sckp      (cfg_sck_inv),
      .wsp       (cfg_ws_inv),
      .del       (cfg_delay),
      .padfirst  (cfg_pad_first),
      .padval    (cfg_pad_val),
      .cfg       (cfg_live),
      .ok        (ok_live)
   );

   // configuration is captured only while idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         ok_q  <= 1'b0;
         div_q <= '0;
      end else if (!busy) begin
         cfg_q <= cfg_live;
         ok_q  <= ok_live;
         div_q <= cfg_div;
      end
   end

   assign cfg_err = !ok_live;

   sat_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .cont    (cont),
      .div     (div_q),
      .tick    (tick),
      .sck_int (sck_int)
   );

   sat_frame_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .cfg_ok     (ok_q),
      .swl        (cfg_q.swl),
      .dwl        (cfg_q.dwl),
      .nw         (cfg_q.nw),
      .padfirst   (cfg_q.padfirst),
      .tick       (tick),
      .busy       (busy),
      .go         (go),
      .cont       (cont),
      .launch     (launch),
      .stop       (stop),
      .in_data    (in_data),
      .word_start (word_start),
      .ws_int     (ws_int)
   );

   sat_shifter #(.MAXW(MAXW)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch     (launch),
      .stop       (stop),
      .in_data    (in_data),
      .word_start (word_start),
      .dwl        (cfg_q.dwl),
      .padval     (cfg_q.padval),
      .s_valid    (s_valid),
      .s_data     (s_data),
      .ufl_clr    (ufl_clr),
      .s_ready    (s_ready),
      .sd_cur     (sd_cur),
      .sd_prev    (sd_prev),
      .underflow  (underflow)
   );

   assign sck = sck_int ^ cfg_q.sckp;
   assign ws  = ws_int ^ cfg_q.wsp;
   assign sd  = cfg_q.del ? sd_prev : sd_cur;

   a_r8_ready_only_running: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> (ok_q && go));

endmodule

// File: tb/tb_sat_tx.sv
module tb_sat_tx;

   localparam int CLK_PERIOD = 10;
   localparam int DIV_W      = 8;
   localparam int MAXW       = 24;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             en = 1'b0;
   logic [2:0]       cfg_swl = 3'd3;
   logic [2:0]       cfg_dwl = 3'd1;
   logic [1:0]       cfg_chan = 2'd0;
   logic [DIV_W-1:0] cfg_div = '0;
   logic             cfg_sck_inv = 1'b0;
   logic             cfg_ws_inv = 1'b0;
   logic             cfg_delay = 1'b0;
   logic             cfg_pad_first = 1'b0;
   logic             cfg_pad_val = 1'b0;
   logic             s_valid = 1'b0;
   logic [MAXW-1:0]  s_data;
   logic             s_ready;
   logic             ufl_clr = 1'b0;
   logic             underflow, cfg_err, sck, ws, sd;

   sat_tx #(.DIV_W(DIV_W), .MAXW(MAXW)) dut (
      .clk(clk), .rst_n(rst_n), .en(en),
      .cfg_swl(cfg_swl), .cfg_dwl(cfg_dwl), .cfg_chan(cfg_chan), .cfg_div(cfg_div),
      .cfg_sck_inv(cfg_sck_inv), .cfg_ws_inv(cfg_ws_inv), .cfg_delay(cfg_delay),
      .cfg_pad_first(cfg_pad_first), .cfg_pad_val(cfg_pad_val),
      .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
      .ufl_clr(ufl_clr), .underflow(underflow), .cfg_err(cfg_err),
      .sck(sck), .ws(ws), .sd(sd)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [MAXW-1:0] smp(input int i);
      logic [31:0] x;
      x = 32'(i) * 32'h9E3779B1 + 32'h01234567;
      x = x ^ (x >> 13);
      return x[MAXW-1:0];
   endfunction

   function automatic int swl_b(input int c);
      int t[8] = '{8, 16, 24, 32, 48, 64, 128, 256};
      return t[c];
   endfunction

   function automatic int dwl_b(input int c);
      int t[6] = '{8, 16, 18, 20, 22, 24};
      return t[c];
   endfunction

   // sample source: index advances on every accepted handshake
   int sidx = 0;
   int hs = 0;
   assign s_data = smp(sidx);
   always @(posedge clk) begin
      if (s_valid && s_ready) begin
         sidx <= sidx + 1;
         hs   <= hs + 1;
      end
   end

   // scoreboard monitor: samples ws/sd on the receiver edge
   logic [1:0] exp_q[$];
   string      cur_tag = "";
   bit         arm = 1'b0;
   logic       sck_prev = 1'b1;
   logic       samp_lvl = 1'b1;
   int         nedges = 0;
   int         last_edge = 0;
   int         exp_per = 2;
   int         slot = 0;

   always @(negedge clk) begin
      if (arm && (sck !== sck_prev) && (sck === samp_lvl)) begin
         if (nedges > 0)
            chk((cyc - last_edge) == exp_per, "R5", "bit clock period", cyc - last_edge, exp_per);
         last_edge = cyc;
         nedges++;
         if (exp_q.size() > 0) begin
            logic [1:0] e;
            e = exp_q.pop_front();
            checks++;
            if ({ws, sd} !== e) begin
               errors++;
               $display("FAIL %s slot %0d: actual ws=%b sd=%b expected ws=%b sd=%b",
                        cur_tag, slot, ws, sd, e[1], e[0]);
            end
            slot++;
         end
      end
      sck_prev = sck;
   end

   task automatic run_test(input string tag, input int swc, input int dwc, input int ch,
                           input int div, input bit sinv, input bit winv, input bit del,
                           input bit pf, input bit pv, input bit valid, input int nf);
      int swl, dwl, nw, dbits, ds, base, hs0;
      logic [1:0] uq[$];
      swl = swl_b(swc); dwl = dwl_b(dwc); nw = ch + 1; dbits = nw * dwl;
      ds  = pf ? swl - dbits : 0;
      @(negedge clk);
      en = 1'b0;
      cfg_swl = 3'(swc); cfg_dwl = 3'(dwc); cfg_chan = 2'(ch); cfg_div = DIV_W'(div);
      cfg_sck_inv = sinv; cfg_ws_inv = winv; cfg_delay = del;
      cfg_pad_first = pf; cfg_pad_val = pv; s_valid = valid;
      repeat (10) @(negedge clk);
      base = sidx; hs0 = hs;
      exp_q.delete();
      for (int f = 0; f < nf; f++)
         for (int h = 0; h < 2; h++)
            for (int p = 0; p < swl; p++) begin
               logic d;
               if (p >= ds && p < ds + dbits) begin
                  int k, b;
                  logic [MAXW-1:0] w;
                  k = (p - ds) / dwl;
                  b = dwl - 1 - ((p - ds) % dwl);
                  w = smp(base + (f * 2 + h) * nw + k);
                  d = valid ? w[b] : 1'b0;
               end else begin
                  d = pv;
               end
               uq.push_back({1'(h) ^ winv, d});
            end
      for (int i = 0; i < uq.size(); i++) begin
         logic dd;
         if (del) dd = (i == 0) ? 1'b0 : uq[i-1][0];
         else     dd = uq[i][0];
         exp_q.push_back({uq[i][1], dd});
      end
      cur_tag = tag; slot = 0; nedges = 0;
      exp_per = 2 * (div + 1);
      samp_lvl = ~sinv; sck_prev = sck;
      chk(cfg_err == 1'b0, "R6", "cfg_err on valid config", int'(cfg_err), 0);
      arm = 1'b1;
      en = 1'b1;
      wait (nedges >= nf * 2 * swl);
      en = 1'b0;
      repeat (2 * swl * exp_per + 10) @(negedge clk);
      arm = 1'b0;
      chk(exp_q.size() == 0, tag, "expected bits left unseen", exp_q.size(), 0);
      chk(nedges == nf * 2 * swl, "R10", "bit edges, whole frames", nedges, nf * 2 * swl);
      chk((hs - hs0) == (valid ? nf * 2 * nw : 0), "R8", "accepted samples", hs - hs0,
          valid ? nf * 2 * nw : 0);
      chk(sck === ~sinv, "R10", "idle sck level", int'(sck), int'(~sinv));
      chk(ws === ~winv, "R10", "idle ws level", int'(ws), int'(~winv));
      chk(sd === 1'b0, "R10", "idle sd", int'(sd), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      int toggles, readies;
      logic sp;
      repeat (3) @(negedge clk);
      // reset state (R10 idle levels, R9 flag clear)
      chk(sck === 1'b1, "R10", "reset sck", int'(sck), 1);
      chk(ws === 1'b1, "R10", "reset ws", int'(ws), 1);
      chk(sd === 1'b0, "R10", "reset sd", int'(sd), 0);
      chk(s_ready === 1'b0, "R8", "reset s_ready", int'(s_ready), 0);
      chk(underflow === 1'b0, "R9", "reset underflow", int'(underflow), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // one word per system word, padding after, delayed data
      run_test("R1 R2 R4", 3, 1, 0, 0, 0, 0, 1, 0, 0, 1, 2);
      // four 8-bit words exactly filling a 32-bit system word
      run_test("R8 R1", 3, 0, 3, 0, 0, 0, 0, 0, 0, 1, 2);
      // padding first, pad value 1, delay, slower clock
      run_test("R3 R7 R4", 4, 3, 1, 1, 0, 0, 1, 1, 1, 1, 2);
      // inverted clock and word select, three words, padding after with value 1
      run_test("R5 R7", 3, 0, 2, 2, 1, 1, 0, 0, 1, 1, 2);
      // 24-bit words in 64-bit system words, padding first, no delay
      run_test("R3 R1", 5, 5, 1, 0, 0, 0, 0, 1, 0, 1, 1);
      chk(underflow === 1'b0, "R9", "no underflow while fed", int'(underflow), 0);

      // starved: zeros and sticky flag
      run_test("R9", 3, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      chk(underflow === 1'b1, "R9", "underflow set", int'(underflow), 1);
      repeat (5) @(negedge clk);
      chk(underflow === 1'b1, "R9", "underflow sticky", int'(underflow), 1);
      ufl_clr = 1'b1;
      @(negedge clk);
      ufl_clr = 1'b0;
      @(negedge clk);
      chk(underflow === 1'b0, "R9", "underflow cleared", int'(underflow), 0);

      // invalid: three 16-bit words in a 32-bit system word
      s_valid = 1'b1;
      cfg_swl = 3'd3; cfg_dwl = 3'd1; cfg_chan = 2'd2; cfg_div = '0;
      cfg_sck_inv = 1'b0; cfg_ws_inv = 1'b0;
      repeat (5) @(negedge clk);
      chk(cfg_err === 1'b1, "R6", "cfg_err over-long config", int'(cfg_err), 1);
      en = 1'b1;
      toggles = 0; readies = 0; sp = sck;
      repeat (300) begin
         @(negedge clk);
         if (sck !== sp) toggles++;
         if (s_ready === 1'b1) readies++;
         sp = sck;
      end
      chk(toggles == 0, "R6", "bit clock edges on invalid config", toggles, 0);
      chk(readies == 0, "R6", "s_ready on invalid config", readies, 0);
      en = 1'b0;
      cfg_chan = 2'd0; cfg_dwl = 3'd6;
      @(negedge clk);
      chk(cfg_err === 1'b1, "R6", "cfg_err on length code 6", int'(cfg_err), 1);
      cfg_dwl = 3'd7;
      @(negedge clk);
      chk(cfg_err === 1'b1, "R6", "cfg_err on length code 7", int'(cfg_err), 1);
      cfg_dwl = 3'd1;
      @(negedge clk);
      chk(cfg_err === 1'b0, "R6", "cfg_err on valid config", int'(cfg_err), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule